// File: doc/BRIEF.md
# Programmable Video Blanking Generator

This block decides, pixel by pixel, whether an interlaced NTSC or PAL timing chain should accept active picture data. It keeps a horizontal pixel counter that restarts on every HSYNC leading-edge pulse and a line counter that restarts on the VSYNC leading-edge pulse opening an odd field. Two small state machines compare these counters against programmable values. The horizontal machine closes the picture window at a 10-bit start count and reopens it at an 8-bit end count. The vertical machine closes the window at a programmable line and keeps it closed for a fixed number of lines. In even fields the vertical start line is moved down by a standard-dependent offset.

The result drives an active-low mask output and an internal pixel-accept gate. When the mask pin is configured as an input (`mask_drive` low), the comparators no longer steer anything. The gate then follows the external mask level, and the mask output is held released (high).

The horizontal machine has states H_OPEN and H_SHUT. H_OPEN goes to H_SHUT on a start-count match, and H_SHUT goes to H_OPEN on an end-count match. The vertical machine has states V_OPEN and V_SHUT. V_OPEN goes to V_SHUT when the line counter equals the field's target line. V_SHUT goes back to V_OPEN on the HSYNC pulse that ends the last blanked line.

Top module: `vid_blank_gen`

## Requirements
- R1: While `rst_n` is low, `vid_mask_n` is 1 and `pix_gate` is 0.
- R2: The horizontal count is H_REF (default 0) in the cycle after the cycle in which `hsync_lead` is sampled high, and rises by one per cycle after that. In drive mode, the cycle in which the count equals the start value `{hstart_hi, hstart_lo}` is the last open cycle. `vid_mask_n` and `pix_gate` go to 0 at the clock edge that ends it.
- R3: In drive mode, when the horizontal count equals the zero-extended 8-bit `hend` and no vertical blanking is in force, `vid_mask_n` and `pix_gate` return to 1 at the following clock edge.
- R4: The start value uses the high bits. With `hstart_hi`=1 and `hstart_lo`=4 (value 260), the window closes after count 260 and not at count 4.
- R5: The line counter is cleared by `vsync_lead` sampled with `field_odd`=1, and takes priority over HSYNC in that cycle. Each other `hsync_lead` adds one to it. A `vsync_lead` with `field_odd`=0 leaves it unchanged.
- R6: In odd fields (`field_odd`=1), lines n through n+VLEN-1 are masked for their whole length, where n = `{vstart_hi, vstart_lo}` and VLEN defaults to 20. Line n+VLEN opens normally again.
- R7: In even fields with `std_pal`=0, the vertical masking starts at line n+262.
- R8: In even fields with `std_pal`=1, the vertical masking starts at line n+313.
- R9: With `mask_drive`=0, `vid_mask_n` is 1 one cycle later whatever the registers hold. `pix_gate` equals the previous cycle's `ext_mask_n`.
- R10: Without HSYNC pulses, the horizontal counter stops at 1023 and does not wrap. A line that runs past 1023 counts produces no second end match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1x pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_lead | input | 1 | One-cycle pulse on the HSYNC leading edge |
| vsync_lead | input | 1 | One-cycle pulse on the VSYNC leading edge |
| field_odd | input | 1 | 1 during odd fields, 0 during even fields |
| std_pal | input | 1 | 0 selects NTSC line offsets, 1 selects PAL |
| mask_drive | input | 1 | 1: mask pin is an output driven by the comparators; 0: mask pin is an input |
| ext_mask_n | input | 1 | External mask level used when `mask_drive` is 0 |
| hstart_lo | input | 8 | Low byte of the horizontal blank start count |
| hstart_hi | input | 2 | High bits of the horizontal blank start count |
| hend | input | 8 | Horizontal count at which pixel input resumes |
| vstart_lo | input | 8 | Low byte of the vertical blank start line |
| vstart_hi | input | 1 | High bit of the vertical blank start line |
| vid_mask_n | output | 1 | Registered mask output, low while blanked |
| pix_gate | output | 1 | Registered pixel-accept gate, high when pixels are taken |

## Verification
The hardest conditions to reach from the ports are the even-field vertical windows. They only occur after several hundred HSYNC pulses, and only after an even-field VSYNC that must leave the line counter alone. The stimulus uses 40-clock lines so that a whole NTSC run of 300 lines and a PAL run of 346 lines fit in a short run. Every line is probed in the middle of its horizontally open region, so each line of vertical masking is checked directly. A single line of 1300 clocks with no HSYNC drives the horizontal counter into its saturated value.

// File: rtl/vbg_pkg.sv
package vbg_pkg;

    typedef enum logic {
        H_OPEN = 1'b0,
        H_SHUT = 1'b1
    } hstate_t;

    typedef enum logic {
        V_OPEN = 1'b0,
        V_SHUT = 1'b1
    } vstate_t;

    localparam int EVEN_OFS_NTSC = 262;
    localparam int EVEN_OFS_PAL  = 313;

endpackage

// File: rtl/vbg_counters.sv
module vbg_counters #(
    parameter int HW    = 10,
    parameter int VW    = 10,
    parameter int H_REF = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsync_lead,
    input  logic          vsync_lead,
    input  logic          field_odd,
    output logic [HW-1:0] hcnt,
    output logic [VW-1:0] vcnt
);

    localparam logic [HW-1:0] H_REF_V = HW'(H_REF);
    localparam logic [HW-1:0] H_MAX   = '1;
    localparam logic [VW-1:0] V_MAX   = '1;

    // pixel counter: reloads on HSYNC, saturates otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
        end else if (hsync_lead) begin
            hcnt <= H_REF_V;
        end else if (hcnt != H_MAX) begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // line counter: odd-field VSYNC clears, HSYNC steps
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vcnt <= '0;
        end else if (vsync_lead && field_odd) begin
            vcnt <= '0;
        end else if (hsync_lead && (vcnt != V_MAX)) begin
            vcnt <= vcnt + 1'b1;
        end
    end

endmodule

// File: rtl/vbg_hfsm.sv
module vbg_hfsm
    import vbg_pkg::*;
#(
    parameter int HW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] hcnt,
    input  logic [HW-1:0] hstart,
    input  logic [HW-1:0] hend,
    output logic          h_shut_nxt
);

    hstate_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= H_OPEN;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            H_OPEN: if (hcnt == hstart) state_nxt = H_SHUT;
            H_SHUT: if (hcnt == hend)   state_nxt = H_OPEN;
        endcase
        h_shut_nxt = (state_nxt == H_SHUT);
    end

endmodule

// File: rtl/vbg_vfsm.sv
module vbg_vfsm
    import vbg_pkg::*;
#(
    parameter int VW   = 10,
    parameter int NW   = 9,
    parameter int VLEN = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsync_lead,
    input  logic          field_odd,
    input  logic          std_pal,
    input  logic [VW-1:0] vcnt,
    input  logic [NW-1:0] vstart,
    output logic          v_shut_nxt
);

    localparam int            LCW      = $clog2(VLEN + 1);
    localparam logic [LCW-1:0] LAST_LN = LCW'(VLEN - 1);
    localparam logic [VW-1:0] OFS_N    = VW'(EVEN_OFS_NTSC);
    localparam logic [VW-1:0] OFS_P    = VW'(EVEN_OFS_PAL);

    vstate_t        state, state_nxt;
    logic [LCW-1:0] lines, lines_nxt;
    logic [VW-1:0]  target;

    always_comb begin
        if (field_odd) begin
            target = VW'(vstart);
        end else if (std_pal) begin
            target = VW'(vstart) + OFS_P;
        end else begin
            target = VW'(vstart) + OFS_N;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= V_OPEN;
            lines <= '0;
        end else begin
            state <= state_nxt;
            lines <= lines_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        lines_nxt = lines;
        unique case (state)
            V_OPEN: begin
                if (vcnt == target) begin
                    state_nxt = V_SHUT;
                    lines_nxt = '0;
                end
            end
            V_SHUT: begin
                if (hsync_lead) begin
                    if (lines == LAST_LN) begin
                        state_nxt = V_OPEN;
                    end else begin
                        lines_nxt = lines + 1'b1;
                    end
                end
            end
        endcase
        v_shut_nxt = (state_nxt == V_SHUT);
    end

endmodule

// File: rtl/vid_blank_gen.sv
module vid_blank_gen #(
    parameter int HW    = 10,
    parameter int EW    = 8,
    parameter int VW    = 10,
    parameter int NW    = 9,
    parameter int VLEN  = 20,
    parameter int H_REF = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hsync_lead,
    input  logic               vsync_lead,
    input  logic               field_odd,
    input  logic               std_pal,
    input  logic               mask_drive,
    input  logic               ext_mask_n,
    input  logic [7:0]         hstart_lo,
    input  logic [HW-9:0]      hstart_hi,
    input  logic [EW-1:0]      hend,
    input  logic [7:0]         vstart_lo,
    input  logic [NW-9:0]      vstart_hi,
    output logic               vid_mask_n,
    output logic               pix_gate
);

    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic [HW-1:0] hstart_full;
    logic [HW-1:0] hend_full;
    logic [NW-1:0] vstart_full;
    logic          h_shut_nxt;
    logic          v_shut_nxt;
    logic          shut_nxt;

    assign hstart_full = {hstart_hi, hstart_lo};
    assign hend_full   = {{(HW-EW){1'b0}}, hend};
    assign vstart_full = {vstart_hi, vstart_lo};
    assign shut_nxt    = h_shut_nxt | v_shut_nxt;

    vbg_counters #(.HW(HW), .VW(VW), .H_REF(H_REF)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync_lead (hsync_lead),
        .vsync_lead (vsync_lead),
        .field_odd  (field_odd),
        .hcnt       (hcnt),
        .vcnt       (vcnt)
    );

    vbg_hfsm #(.HW(HW)) u_hfsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hcnt       (hcnt),
        .hstart     (hstart_full),
        .hend       (hend_full),
        .h_shut_nxt (h_shut_nxt)
    );

    vbg_vfsm #(.VW(VW), .NW(NW), .VLEN(VLEN)) u_vfsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync_lead (hsync_lead),
        .field_odd  (field_odd),
        .std_pal    (std_pal),
        .vcnt       (vcnt),
        .vstart     (vstart_full),
        .v_shut_nxt (v_shut_nxt)
    );

    // output flops take the machines' next state, so they move on the
    // same edge as the state registers (one cycle after the match)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vid_mask_n <= 1'b1;
            pix_gate   <= 1'b0;
        end else if (mask_drive) begin
            vid_mask_n <= ~shut_nxt;
            pix_gate   <= ~shut_nxt;
        end else begin
            vid_mask_n <= 1'b1;
            pix_gate   <= ext_mask_n;
        end
    end

endmodule

// File: rtl/vbg_checker.sv
module vbg_checker #(
    parameter int HW    = 10,
    parameter int VW    = 10,
    parameter int H_REF = 0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hsync_lead,
    input logic          vsync_lead,
    input logic          field_odd,
    input logic          mask_drive,
    input logic          ext_mask_n,
    input logic          vid_mask_n,
    input logic          pix_gate,
    input logic [HW-1:0] hcnt,
    input logic [VW-1:0] vcnt,
    input logic [HW-1:0] hstart_full,
    input logic [HW-1:0] hend_full,
    input logic          v_shut_nxt
);

    localparam logic [HW-1:0] H_MAX = '1;
    localparam logic [VW-1:0] V_MAX = '1;

    assert_hsync_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_lead |=> (hcnt == HW'(H_REF)));

    assert_start_shuts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_drive && (hcnt == hstart_full) && (hcnt != hend_full)) |=> !vid_mask_n);

    assert_end_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_drive && (hcnt == hend_full) && (hcnt != hstart_full) && !v_shut_nxt)
        |=> vid_mask_n);

    assert_odd_vsync_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_lead && field_odd) |=> (vcnt == '0));

    assert_line_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_lead && !(vsync_lead && field_odd) && (vcnt != V_MAX))
        |=> (vcnt == $past(vcnt) + 1'b1));

    assert_input_mask_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_drive |=> vid_mask_n);

    assert_input_gate_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_drive |=> (pix_gate == $past(ext_mask_n)));

    assert_hcnt_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hsync_lead && (hcnt == H_MAX)) |=> (hcnt == H_MAX));

endmodule

bind vid_blank_gen vbg_checker #(.HW(HW), .VW(VW), .H_REF(H_REF)) u_vbg_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hsync_lead  (hsync_lead),
    .vsync_lead  (vsync_lead),
    .field_odd   (field_odd),
    .mask_drive  (mask_drive),
    .ext_mask_n  (ext_mask_n),
    .vid_mask_n  (vid_mask_n),
    .pix_gate    (pix_gate),
    .hcnt        (hcnt),
    .vcnt        (vcnt),
    .hstart_full (hstart_full),
    .hend_full   (hend_full),
    .v_shut_nxt  (v_shut_nxt)
);

// File: tb/vid_blank_gen_bench.sv
module vid_blank_gen_bench;

    localparam int VLEN = 20;
    localparam int HREF = 0;
    localparam int HMAX = 1023;
    localparam int VMAX = 1023;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs = 1'b0, vs = 1'b0, fodd = 1'b1, pal = 1'b0;
    logic       drv = 1'b1, ext = 1'b1;
    logic [7:0] hlo = 8'd70;
    logic [1:0] hhi = 2'd0;
    logic [7:0] hend = 8'd10;
    logic [7:0] vlo = 8'd255;
    logic [0:0] vhi = 1'b1;
    logic       mask_n, gate;

    always #10 clk = ~clk;

    vid_blank_gen u_vid_blank_gen (
        .clk(clk), .rst_n(rst_n), .hsync_lead(hs), .vsync_lead(vs),
        .field_odd(fodd), .std_pal(pal), .mask_drive(drv), .ext_mask_n(ext),
        .hstart_lo(hlo), .hstart_hi(hhi), .hend(hend),
        .vstart_lo(vlo), .vstart_hi(vhi),
        .vid_mask_n(mask_n), .pix_gate(gate)
    );

    int    checks = 0, errors = 0;
    string cur_req = "R2";
    bit    cmp_on = 0, done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_h, m_v, m_vl, m_tgt;
    bit m_hb, m_vb, m_mask, m_gate;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_h = 0; m_v = 0; m_vl = 0; m_hb = 0; m_vb = 0;
            m_mask = 1; m_gate = 0;
        end else begin
            bit hb_n, vb_n;
            int vl_n;
            hb_n = m_hb; vb_n = m_vb; vl_n = m_vl;
            if (!m_hb && m_h == {hhi, hlo}) hb_n = 1;
            else if (m_hb && m_h == int'(hend)) hb_n = 0;
            m_tgt = int'({vhi, vlo}) + (fodd ? 0 : (pal ? 313 : 262));
            if (!m_vb) begin
                if (m_v == m_tgt) begin vb_n = 1; vl_n = 0; end
            end else if (hs) begin
                if (m_vl == VLEN - 1) vb_n = 0;
                else vl_n = m_vl + 1;
            end
            m_mask = drv ? !(hb_n || vb_n) : 1'b1;
            m_gate = drv ? !(hb_n || vb_n) : ext;
            m_hb = hb_n; m_vb = vb_n; m_vl = vl_n;
            if (hs) m_h = HREF;
            else if (m_h < HMAX) m_h = m_h + 1;
            if (vs && fodd) m_v = 0;
            else if (hs && m_v < VMAX) m_v = m_v + 1;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk(mask_n === m_mask, {cur_req, " model mask"}, int'(mask_n), int'(m_mask));
            chk(gate === m_gate, {cur_req, " model gate"}, int'(gate), int'(m_gate));
        end
    end

    task automatic finish_up();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            finish_up();
        end
    end

    // one line: probes at negedge index a and b (hcnt = index-1 there)
    task automatic hline(input int len, input bit v, input int a, input bit ea,
                         input int b, input bit eb, input string req);
        hs = 1'b1; vs = v;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            if (i == 1) begin hs = 1'b0; vs = 1'b0; end
            if (i == a) chk(mask_n == ea, req, int'(mask_n), int'(ea));
            if (i == b) chk(gate == eb, req, int'(gate), int'(eb));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mask_n == 1'b1, "R1 reset mask", int'(mask_n), 1);
        chk(gate == 1'b0, "R1 reset gate", int'(gate), 0);
        rst_n = 1'b1;
        cmp_on = 1;

        // R2 / R3: start 70, end 10, 100-clock lines
        cur_req = "R2";
        hline(100, 0, 0, 0, 0, 0, "R2");
        for (int k = 0; k < 4; k++) begin
            hline(100, 0, 71, 1, 72, 0, "R2 close after start count");
            hline(100, 0, 11, 0, 12, 1, "R3 reopen after end count");
        end

        // R4: start 260 via high bits, end 20
        cur_req = "R4";
        hlo = 8'd4; hhi = 2'd1; hend = 8'd20;
        for (int k = 0; k < 3; k++) begin
            hline(300, 0, 261, 1, 262, 0, "R4 ten-bit start");
            hline(300, 0, 6, 0, 21, 0, "R4 low byte alone no match");
        end

        // R10: no HSYNC for a long stretch
        cur_req = "R10";
        hlo = 8'd70; hhi = 2'd0; hend = 8'd10;
        hline(100, 0, 0, 0, 0, 0, "R10");
        hline(1300, 0, 12, 1, 1250, 0, "R10 no wrap reopen");
        chk(mask_n == 1'b0, "R10 still masked", int'(mask_n), 0);

        // R5 / R6 / R7: NTSC, short lines, start line 8
        hlo = 8'd30; hend = 8'd5; vlo = 8'd8; vhi = 1'b0;
        fodd = 1'b1; pal = 1'b0;
        for (int k = 0; k < 300; k++) begin
            bit blk;
            if (k == 262) fodd = 1'b0;
            if (k < 262) begin
                cur_req = "R6";
                blk = (k >= 8 && k < 8 + VLEN);
                hline(40, (k == 0), 15, !blk, 15, !blk, "R5/R6 odd field line");
            end else begin
                cur_req = "R7";
                blk = (k >= 270 && k < 270 + VLEN);
                hline(40, (k == 262), 15, !blk, 15, !blk, "R5/R7 even NTSC line");
            end
        end

        // R8: PAL
        pal = 1'b1; fodd = 1'b1;
        for (int k = 0; k < 346; k++) begin
            bit blk;
            if (k == 313) fodd = 1'b0;
            if (k < 313) begin
                cur_req = "R6";
                blk = (k >= 8 && k < 8 + VLEN);
                hline(40, (k == 0), 15, !blk, 15, !blk, "R6 PAL odd line");
            end else begin
                cur_req = "R8";
                blk = (k >= 321 && k < 321 + VLEN);
                hline(40, (k == 313), 15, !blk, 15, !blk, "R8 even PAL line");
            end
        end

        // R9: mask pin as input
        cur_req = "R9";
        drv = 1'b0;
        for (int k = 0; k < 3; k++) begin
            ext = 1'b0;
            @(negedge clk);
            chk(gate == 1'b0, "R9 gate follows low", int'(gate), 0);
            chk(mask_n == 1'b1, "R9 mask released", int'(mask_n), 1);
            ext = 1'b1;
            @(negedge clk);
            chk(gate == 1'b1, "R9 gate follows high", int'(gate), 1);
            hline(100, 0, 72, 1, 0, 0, "R9 start count ignored");
        end
        hlo = 8'd0; hend = 8'd0; ext = 1'b0;
        repeat (5) @(negedge clk);
        chk(mask_n == 1'b1, "R9 registers no effect", int'(mask_n), 1);
        chk(gate == 1'b0, "R9 gate from pin", int'(gate), 0);

        finish_up();
    end

endmodule